// File: doc/BRIEF.md
# Key-Locked System Control Register Block

This block is a small bank of board-level status and control registers on a simple 32-bit register bus. Software uses it to read a fixed identification word, drive an LED word, and keep two sets of flags. One flag set returns to zero on reset and the other keeps its contents across reset. Each flag set has its own set address and clear address, so a single bit can change without a read-modify-write. A free-running counter advances at a nominal 24 MHz rate, which is derived from the bus clock.

The block can also ask for a system reset. A reset-control register accepts writes only after software has opened a lock by writing a magic key. The data bit that triggers the request depends on the board variant. The variant is taken from a field of the identification word parameter. On variants with no reset control, the register reads as zero and ignores writes. A qualifying write drives a one-cycle reset-request pulse.

Each access lasts one cycle, marked by a select strobe. Read data is combinational from the address. Any access to an offset outside the map, or to an address that is not word-aligned, produces a one-cycle strobe on the following cycle.

Top module: `sysctl_regs`

## Requirements
- R1: Offset 0x00 reads the ID_WORD parameter, and writes to it have no effect. The board code is ID_WORD bits 27:16.
- R2: Offset 0x08 is a 32-bit LED register that can be read and written. Reset clears it to 0.
- R3: Offset 0x20 is the lock, read as a 16-bit value with zero extension. A write of exactly 0x0000A05F stores 0xA05F. Any other write stores data bits 14:0 with bit 15 cleared, so the lock is open only while it holds 0xA05F. Reset clears it to 0.
- R4: A write to 0x30 ORs the data into the volatile flags, and a write to 0x34 clears the bits that are 1 in the data. A read of 0x30 returns the flags and a read of 0x34 returns 0. Reset clears the flags.
- R5: Offsets 0x38 and 0x3C set and clear the retained flags in the same way, and 0x38 reads them. Reset does not change the retained flags.
- R6: On variants that have reset control, a write to 0x40 is stored only while the lock holds 0xA05F, and 0x40 reads back the stored value. Reset clears that value to 0.
- R7: A stored write to 0x40 whose trigger bit is 1 makes reset_req high for exactly the cycle after the write. The trigger bit is bit 8 for board code 0x100, and bit 2 for board codes 0x178 and 0x182.
- R8: On every other board code (for example 0x140 or 0x190), 0x40 reads 0, writes to it are ignored, and reset_req stays low.
- R9: Offset 0x5C reads a counter. After k rising edges since reset was released, it equals floor(k*TICK_INC/TICK_MOD).
- R10: Offset 0x44 always reads 1 and offset 0x88 always reads 0xFF000000. Writes to these offsets, to 0x00 and to 0x5C change nothing.
- R11: An access to an offset outside the map, or to an address that is not word-aligned, reads 0 and writes nothing. It makes bad_access high for exactly the next cycle. Accesses to mapped offsets never raise bad_access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read access |
| reset_req | output | 1 | One-cycle system reset request |
| bad_access | output | 1 | One-cycle strobe after an access to an unmapped offset |

## Verification
The bench runs three instances at the same time, with board codes 0x100, 0x182 and 0x190. A reset-control write that uses the wrong trigger bit, or that is accepted on a variant with no reset control, therefore shows up as a pulse or readback on the wrong instance.

The lock is driven with a value that has bit 15 set but is not the key, and with the key carrying a nonzero upper half. A design that copies bit 15 through, or compares only the low 16 bits, would leave the lock open when it should be closed.

The bench sets the retained flags and then applies reset. A design that clears them, or that leaves the volatile flags set, returns the wrong value after reset.

Counter samples are compared with floor(k*6/25) at several distances from reset release. An accumulator that drops its remainder, or that fires one cycle early, falls behind or runs ahead of that value.

// File: rtl/sysctl_pkg.sv
// Package: shared register offsets, the lock key, the register-select type
// and the helper that maps a board code to its reset trigger bit.
// Assumes byte addresses with word-aligned registers.
package sysctl_pkg;

    localparam int DW = 32;

    localparam int OFF_ID    = 8'h00;
    localparam int OFF_LED   = 8'h08;
    localparam int OFF_LOCK  = 8'h20;
    localparam int OFF_VSET  = 8'h30;
    localparam int OFF_VCLR  = 8'h34;
    localparam int OFF_NSET  = 8'h38;
    localparam int OFF_NCLR  = 8'h3C;
    localparam int OFF_RCTL  = 8'h40;
    localparam int OFF_ONE   = 8'h44;
    localparam int OFF_CNT   = 8'h5C;
    localparam int OFF_PROC  = 8'h88;

    localparam logic [15:0] LOCK_KEY = 16'hA05F;
    localparam logic [31:0] PROC_VAL = 32'hFF00_0000;

    typedef enum logic [3:0] {
        SEL_ID, SEL_LED, SEL_LOCK, SEL_VSET, SEL_VCLR, SEL_NSET,
        SEL_NCLR, SEL_RCTL, SEL_ONE, SEL_CNT, SEL_PROC, SEL_NONE
    } reg_sel_e;

    // Trigger bit of the reset-control register for a board code; -1 = none.
    function automatic int rst_trig_bit(input logic [11:0] code);
        case (code)
            12'h100:         return 8;
            12'h178, 12'h182: return 2;
            default:         return -1;
        endcase
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
// Address decoder: turns a byte address into a register select.
// Misaligned or unknown addresses map to SEL_NONE. Assumes ADDR_W >= 8.
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    // Full-width compare against each mapped offset.
    always_comb begin
        case (addr)
            ADDR_W'(OFF_ID):   sel = SEL_ID;
            ADDR_W'(OFF_LED):  sel = SEL_LED;
            ADDR_W'(OFF_LOCK): sel = SEL_LOCK;
            ADDR_W'(OFF_VSET): sel = SEL_VSET;
            ADDR_W'(OFF_VCLR): sel = SEL_VCLR;
            ADDR_W'(OFF_NSET): sel = SEL_NSET;
            ADDR_W'(OFF_NCLR): sel = SEL_NCLR;
            ADDR_W'(OFF_RCTL): sel = SEL_RCTL;
            ADDR_W'(OFF_ONE):  sel = SEL_ONE;
            ADDR_W'(OFF_CNT):  sel = SEL_CNT;
            ADDR_W'(OFF_PROC): sel = SEL_PROC;
            default:           sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/sysctl_flags.sv
// Set/clear flag word. RETAIN=1 makes the flags ignore reset.
// Assumes set and clear never arrive in the same cycle (one access per cycle).
module sysctl_flags #(
    parameter int W      = 32,
    parameter bit RETAIN = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] data,
    output logic [W-1:0] flags
);

    logic [W-1:0] flags_q;

    if (RETAIN) begin : g_retained
        // Update the retained flags; reset leaves them untouched.
        always_ff @(posedge clk) begin
            if (set_en)      flags_q <= flags_q | data;
            else if (clr_en) flags_q <= flags_q & ~data;
        end
    end else begin : g_volatile
        // Update the volatile flags; reset clears them.
        always_ff @(posedge clk) begin
            if (!rst_n)      flags_q <= '0;
            else if (set_en) flags_q <= flags_q | data;
            else if (clr_en) flags_q <= flags_q & ~data;
        end
    end

    assign flags = flags_q;

endmodule

// File: rtl/sysctl_lockrst.sv
// Lock register and the lock-protected reset control. BOARD_CODE selects
// the trigger bit, or removes the reset control altogether.
module sysctl_lockrst
    import sysctl_pkg::*;
#(
    parameter logic [11:0] BOARD_CODE = 12'h100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lock_we,
    input  logic          rctl_we,
    input  logic [DW-1:0] wdata,
    output logic [15:0]   lock_val,
    output logic [DW-1:0] rctl_val,
    output logic          req
);

    localparam int  TRIG_BIT = rst_trig_bit(BOARD_CODE);
    localparam bit  HAS_RCTL = (TRIG_BIT >= 0);
    localparam int  TB       = HAS_RCTL ? TRIG_BIT : 0;

    logic [15:0] lock_q;
    logic        open_w;

    // Lock: only the exact key keeps bit 15; anything else clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock_q <= '0;
        else if (lock_we)
            lock_q <= (wdata == {16'h0000, LOCK_KEY}) ? LOCK_KEY : {1'b0, wdata[14:0]};
    end

    assign open_w   = (lock_q == LOCK_KEY);
    assign lock_val = lock_q;

    if (HAS_RCTL) begin : g_rctl
        logic [DW-1:0] level_q;
        logic          req_q;
        // Reset level store and request pulse, gated by the open lock.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                level_q <= '0;
                req_q   <= 1'b0;
            end else begin
                if (rctl_we && open_w) level_q <= wdata;
                req_q <= rctl_we && open_w && wdata[TB];
            end
        end
        assign rctl_val = level_q;
        assign req      = req_q;
    end else begin : g_no_rctl
        assign rctl_val = '0;
        assign req      = 1'b0;
    end

endmodule

// File: rtl/sysctl_tick.sv
// Fractional-rate counter: adds INC to an accumulator modulo MOD on each
// clock, and advances the count each time the accumulator wraps.
// Assumes 0 < INC < MOD.
module sysctl_tick #(
    parameter int INC   = 6,
    parameter int MOD   = 25,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count
);

    localparam int AW = $clog2(MOD + INC) + 1;

    logic [AW-1:0]    acc_q;
    logic [AW-1:0]    acc_sum;
    logic [CNT_W-1:0] cnt_q;

    assign acc_sum = acc_q + AW'(INC);

    // Accumulate the phase and count the wraps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (acc_sum >= AW'(MOD)) begin
            acc_q <= acc_sum - AW'(MOD);
            cnt_q <= cnt_q + 1'b1;
        end else begin
            acc_q <= acc_sum;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/sysctl_regs.sv
// Top level of the system control register bank. Decodes single-cycle bus
// accesses, holds the LED word, and muxes read data from the sub-blocks.
// Assumes CNT_W <= 32 and ADDR_W >= 8.
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter logic [31:0] ID_WORD  = 32'h0100_0000,
    parameter int          TICK_INC = 6,
    parameter int          TICK_MOD = 25,
    parameter int          CNT_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              reset_req,
    output logic              bad_access
);

    localparam logic [11:0] BOARD_CODE = ID_WORD[27:16];

    reg_sel_e         sel;
    logic             wr_en;
    logic             rd_en;
    logic [DW-1:0]    led_q;
    logic             bad_q;
    logic [15:0]      lock_val;
    logic [DW-1:0]    rctl_val;
    logic [DW-1:0]    vflags;
    logic [DW-1:0]    nflags;
    logic [CNT_W-1:0] cnt_val;

    assign wr_en = bus_sel && bus_wr;
    assign rd_en = bus_sel && !bus_wr;

    sysctl_decode #(.ADDR_W(ADDR_W)) dec_i (
        .addr (bus_addr),
        .sel  (sel)
    );

    sysctl_lockrst #(.BOARD_CODE(BOARD_CODE)) lk_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_we  (wr_en && sel == SEL_LOCK),
        .rctl_we  (wr_en && sel == SEL_RCTL),
        .wdata    (bus_wdata),
        .lock_val (lock_val),
        .rctl_val (rctl_val),
        .req      (reset_req)
    );

    sysctl_flags #(.W(DW), .RETAIN(1'b0)) vfl_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (wr_en && sel == SEL_VSET),
        .clr_en (wr_en && sel == SEL_VCLR),
        .data   (bus_wdata),
        .flags  (vflags)
    );

    sysctl_flags #(.W(DW), .RETAIN(1'b1)) nfl_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (wr_en && sel == SEL_NSET),
        .clr_en (wr_en && sel == SEL_NCLR),
        .data   (bus_wdata),
        .flags  (nflags)
    );

    sysctl_tick #(.INC(TICK_INC), .MOD(TICK_MOD), .CNT_W(CNT_W)) tk_i (
        .clk   (clk),
        .rst_n (rst_n),
        .count (cnt_val)
    );

    // LED word and the bad-access strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led_q <= '0;
            bad_q <= 1'b0;
        end else begin
            if (wr_en && sel == SEL_LED) led_q <= bus_wdata;
            bad_q <= bus_sel && (sel == SEL_NONE);
        end
    end

    assign bad_access = bad_q;

    // Read data multiplexer; zero outside read accesses.
    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (sel)
                SEL_ID:   bus_rdata = ID_WORD;
                SEL_LED:  bus_rdata = led_q;
                SEL_LOCK: bus_rdata = {16'h0000, lock_val};
                SEL_VSET: bus_rdata = vflags;
                SEL_NSET: bus_rdata = nflags;
                SEL_RCTL: bus_rdata = rctl_val;
                SEL_ONE:  bus_rdata = 32'd1;
                SEL_CNT:  bus_rdata = 32'(cnt_val);
                SEL_PROC: bus_rdata = PROC_VAL;
                default:  bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/sysctl_regs_chk.sv
// Checker for sysctl_regs: protocol-level properties over ports and the
// state that the sub-blocks drive. Attached by bind below.
module sysctl_regs_chk #(
    parameter int          ADDR_W  = 8,
    parameter logic [31:0] ID_WORD = 32'h0100_0000,
    parameter int          CNT_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              reset_req,
    input logic              bad_access,
    input logic [15:0]       lock_val,
    input logic [31:0]       vflags,
    input logic [CNT_W-1:0]  cnt_val
);

    localparam bit HAS_RCTL = (sysctl_pkg::rst_trig_bit(ID_WORD[27:16]) >= 0);

    logic w_vset, w_vclr, w_rctl, r_rctl, r_one;
    assign w_vset = bus_sel && bus_wr  && bus_addr == ADDR_W'(8'h30);
    assign w_vclr = bus_sel && bus_wr  && bus_addr == ADDR_W'(8'h34);
    assign w_rctl = bus_sel && bus_wr  && bus_addr == ADDR_W'(8'h40);
    assign r_rctl = bus_sel && !bus_wr && bus_addr == ADDR_W'(8'h40);
    assign r_one  = bus_sel && !bus_wr && bus_addr == ADDR_W'(8'h44);

    AST_LOCK_BIT15_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        lock_val[15] |-> lock_val == 16'hA05F); // R3
    AST_VFLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        w_vset |=> ((vflags & $past(bus_wdata)) == $past(bus_wdata))); // R4
    AST_VFLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        w_vclr |=> ((vflags & $past(bus_wdata)) == 32'd0)); // R4
    AST_REQ_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(w_rctl && lock_val == 16'hA05F)); // R7
    AST_NO_RCTL_RAZ: assert property (@(posedge clk) disable iff (!rst_n)
        (r_rctl && !HAS_RCTL) |-> bus_rdata == 32'd0); // R8
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_val != '1) |=> (cnt_val - $past(cnt_val)) <= CNT_W'(1)); // R9
    AST_CONST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        r_one |-> bus_rdata == 32'd1); // R10
    AST_BAD_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        bad_access |-> $past(bus_sel)); // R11

endmodule

bind sysctl_regs sysctl_regs_chk #(
    .ADDR_W  (ADDR_W),
    .ID_WORD (ID_WORD),
    .CNT_W   (CNT_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .reset_req  (reset_req),
    .bad_access (bad_access),
    .lock_val   (lock_val),
    .vflags     (vflags),
    .cnt_val    (cnt_val)
);

// File: tb/sysctl_regs_tb_top.sv
// Directed bench: three variants (board codes 0x100, 0x182, 0x190) share
// one bus; each task drives one scenario and checks its own results.
module sysctl_regs_tb_top;

    localparam int INC = 6;
    localparam int MOD = 25;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rd_a, rd_b, rd_c;
    logic        rq_a, rq_b, rq_c;
    logic        bd_a, bd_b, bd_c;

    int n_chk = 0;
    int n_bad = 0;
    longint edges = 0;

    always #2 clk = ~clk;

    always @(posedge clk) if (rst_n) edges <= edges + 1; else edges <= 0;

    sysctl_regs #(.ID_WORD(32'h0100_0000), .TICK_INC(INC), .TICK_MOD(MOD)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_a),
        .reset_req(rq_a), .bad_access(bd_a));
    sysctl_regs #(.ID_WORD(32'h0182_0000), .TICK_INC(INC), .TICK_MOD(MOD)) dut_b (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_b),
        .reset_req(rq_b), .bad_access(bd_b));
    sysctl_regs #(.ID_WORD(32'h0190_0000), .TICK_INC(INC), .TICK_MOD(MOD)) dut_c (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_c),
        .reset_req(rq_c), .bad_access(bd_c));

    // Captured values from the most recent access.
    logic [31:0] ga, gb, gc;
    logic [2:0]  p1, p2, bad1, bad2;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        p1 = {rq_a, rq_b, rq_c}; bad1 = {bd_a, bd_b, bd_c};
        bus_sel = 1'b0; bus_wr = 1'b0;
        @(negedge clk);
        p2 = {rq_a, rq_b, rq_c}; bad2 = {bd_a, bd_b, bd_c};
    endtask

    task automatic rd(input logic [7:0] a);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        ga = rd_a; gb = rd_b; gc = rd_c;
        @(negedge clk);
        bad1 = {bd_a, bd_b, bd_c};
        bus_sel = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        rd(8'h08); chk("R2 led reset", ga, 32'h0);
        rd(8'h20); chk("R3 lock reset", ga, 32'h0);
        rd(8'h30); chk("R4 vflags reset", ga, 32'h0);
        rd(8'h40); chk("R6 rctl reset", ga, 32'h0);
        chk("R7 no req at reset", {29'd0, rq_a, rq_b, rq_c}, 32'h0);
    endtask

    task automatic t_id();
        rd(8'h00);
        chk("R1 id a", ga, 32'h0100_0000);
        chk("R1 id b", gb, 32'h0182_0000);
        chk("R1 id c", gc, 32'h0190_0000);
        wr(8'h00, 32'hDEAD_BEEF);
        rd(8'h00); chk("R1 id write ignored", ga, 32'h0100_0000);
    endtask

    task automatic t_led();
        wr(8'h08, 32'hA5A5_5A5A); rd(8'h08); chk("R2 led", ga, 32'hA5A5_5A5A);
        wr(8'h08, 32'h0000_0001); rd(8'h08); chk("R2 led 2", gc, 32'h0000_0001);
    endtask

    task automatic t_lock();
        wr(8'h20, 32'h1234_ABCD); rd(8'h20); chk("R3 lock non-key", ga, 32'h0000_2BCD);
        wr(8'h20, 32'h0001_A05F); rd(8'h20); chk("R3 lock key with upper bits", ga, 32'h0000_205F);
        wr(8'h20, 32'h0000_A05F); rd(8'h20); chk("R3 lock key", ga, 32'h0000_A05F);
        wr(8'h20, 32'h0000_0000); rd(8'h20); chk("R3 lock close", ga, 32'h0);
    endtask

    task automatic t_rctl();
        // Lock closed: ignored everywhere.
        wr(8'h40, 32'h0000_0104);
        chk("R6 closed no pulse", {29'd0, p1}, 32'h0);
        rd(8'h40); chk("R6 closed a", ga, 32'h0); chk("R6 closed b", gb, 32'h0);
        // Lock open: both trigger bits.
        wr(8'h20, 32'h0000_A05F);
        wr(8'h40, 32'h0000_0104);
        chk("R7 pulse both", {29'd0, p1}, 32'h6);
        chk("R7 pulse one cycle", {29'd0, p2}, 32'h0);
        rd(8'h40);
        chk("R6 stored a", ga, 32'h0000_0104);
        chk("R6 stored b", gb, 32'h0000_0104);
        chk("R8 raz c", gc, 32'h0);
        wr(8'h40, 32'h0000_0100);
        chk("R7 bit8 only variant 100", {29'd0, p1}, 32'h4);
        wr(8'h40, 32'h0000_0004);
        chk("R7 bit2 only variant 182", {29'd0, p1}, 32'h2);
        wr(8'h40, 32'h0000_0000);
        chk("R8 no pulse zero data", {29'd0, p1}, 32'h0);
        wr(8'h20, 32'h0);
    endtask

    task automatic t_flags();
        wr(8'h30, 32'h0000_00F0); wr(8'h30, 32'h0000_000F);
        rd(8'h30); chk("R4 set accumulate", ga, 32'h0000_00FF);
        wr(8'h34, 32'h0000_003C);
        rd(8'h30); chk("R4 clear", ga, 32'h0000_00C3);
        rd(8'h34); chk("R4 clear addr reads 0", ga, 32'h0);
        wr(8'h3C, 32'hFFFF_FFFF); wr(8'h38, 32'h8000_0081);
        wr(8'h3C, 32'h8000_0000);
        rd(8'h38); chk("R5 nv set/clear", ga, 32'h0000_0081);
    endtask

    task automatic t_reset_keep();
        wr(8'h08, 32'h0000_00AA);
        wr(8'h20, 32'h0000_A05F);
        wr(8'h40, 32'h0000_0010);
        do_reset();
        rd(8'h38); chk("R5 nv kept over reset", ga, 32'h0000_0081);
        rd(8'h30); chk("R4 vflags cleared", ga, 32'h0);
        rd(8'h08); chk("R2 led cleared", ga, 32'h0);
        rd(8'h20); chk("R3 lock cleared", ga, 32'h0);
        rd(8'h40); chk("R6 level cleared", ga, 32'h0);
    endtask

    task automatic t_counter();
        longint e;
        do_reset();
        for (int i = 0; i < 3; i++) begin
            repeat (37 * (i + 1)) @(negedge clk);
            @(negedge clk);
            bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h5C;
            #1;
            e = (edges * INC) / MOD;
            chk("R9 counter", rd_a, 32'(e));
            @(negedge clk); bus_sel = 1'b0;
        end
        wr(8'h5C, 32'h0); rd(8'h5C);
        chk("R10 counter write ignored", {31'd0, (ga != 32'h0)}, 32'h1);
    endtask

    task automatic t_consts();
        rd(8'h44); chk("R10 one", ga, 32'd1);
        rd(8'h88); chk("R10 proc", gb, 32'hFF00_0000);
        chk("R11 no bad on mapped", {29'd0, bad1}, 32'h0);
        wr(8'h44, 32'h0); rd(8'h44); chk("R10 one after write", ga, 32'd1);
    endtask

    task automatic t_unmapped();
        wr(8'h08, 32'h0000_5555);
        rd(8'h24); chk("R11 read 0", ga, 32'h0);
        chk("R11 bad on read", {29'd0, bad1}, 32'h7);
        wr(8'h60, 32'hFFFF_FFFF);
        chk("R11 bad on write", {29'd0, bad1}, 32'h7);
        chk("R11 bad one cycle", {29'd0, bad2}, 32'h0);
        wr(8'h09, 32'hFFFF_FFFF);
        chk("R11 misaligned bad", {29'd0, bad1}, 32'h7);
        rd(8'h08); chk("R11 led untouched", ga, 32'h0000_5555);
    endtask

    initial begin
        fork
            begin
                do_reset();
                t_reset_state();
                t_id();
                t_led();
                t_lock();
                t_rctl();
                t_flags();
                t_reset_keep();
                t_counter();
                t_consts();
                t_unmapped();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule